// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of an external flash and decides whether a program or erase operation that software has just launched is finished. A one-cycle `start` pulse wakes it. It then reads the device status word in pairs over a request/acknowledge read port and compares one chosen toggle bit between the two reads of each pair. A bit that stays put means the device has stopped its internal algorithm. A bit that changes means work is still in progress.

When the bit changes, the poller looks at the timeout-exceeded bit from the second read of the pair. If that bit is clear, it simply polls again. If it is set, the poller always takes one more pair of reads. This extra pair catches a device whose toggle bit froze at the same moment the timeout bit rose. If the toggle bit is still changing on that extra pair, the operation has failed. The poller then writes the reset command to the device so that it returns to array-read mode, and it raises a sticky failure flag.

A pair budget caps how long the poller will wait. When the budget is used up, it takes the same failure path. Success is signalled by a single-cycle `done` pulse.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: Under reset, and in the first cycle after reset is released, `busy`, `done`, `fail`, `rd_req` and `wr_req` are all low.
- R2: A `start` pulse seen while idle raises `busy` and begins a series of read pairs, all at address `STATUS_ADDR`. `rd_req` stays high until `rd_ack` is sampled high, and each cycle with both `rd_req` and `rd_ack` high completes exactly one read.
- R3: If bit `TOGGLE_BIT` (bit 6 in the bench) has the same value in both reads of a pair, the poller finishes with a one-cycle `done` pulse, with `busy` low in that same cycle, and issues no write. Every other data bit, except the timeout bit, is ignored.
- R4: If the toggle bit differs within a pair and bit `TIMEOUT_BIT` (bit 5 in the bench) of the pair's second read is 0, the poller starts another pair.
- R5: If the toggle bit differs and the timeout bit of the second read is 1, the poller takes exactly one more pair. A match on that pair ends in `done`.
- R6: If the toggle bit still differs on the pair taken after the timeout bit was seen high, the operation is reported as failed.
- R7: On failure the poller issues exactly one write of `RESET_CMD` (0xF0 in the bench) to `RESET_ADDR` (0x0555 in the bench). `wr_req` is held until `wr_ack`, `fail` goes high, no `done` pulse is given, and `busy` falls after the write is acknowledged.
- R8: At most `MAX_PAIRS` read pairs are taken per operation. If the last permitted pair still shows a changing toggle bit, the failure path of R7 is taken instead of a new pair.
- R9: A `start` pulse while `busy` is high has no effect on the read sequence or the result.
- R10: `fail` stays high until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| rd_req | output | 1 | Status read request, held until acknowledged |
| rd_addr | output | ADDR_W | Status read address |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid with it |
| rd_data | input | DATA_W | Status word returned by the device |
| wr_req | output | 1 | Reset command write request, held until acknowledged |
| wr_addr | output | ADDR_W | Reset command address |
| wr_data | output | DATA_W | Reset command value |
| wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | High from an accepted start until the result is given |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | Sticky failure flag |

## Verification
The key corner case is a toggle bit that stops in the very pair where the timeout bit first reads high. A design that treated the timeout bit as final would report failure there, when the correct result is success. A second case is a toggle bit that keeps changing on the recheck pair; a design that skipped the recheck, or did not write the reset command, would get the read count or the write wrong.

The budget is checked on both sides of its edge: success on the last allowed pair, and failure when one more pair would be needed. This exposes an off-by-one in the pair counter. The bench also makes a noise bit toggle on every read, to expose a comparison made on the wrong bit. Finally, it pulses `start` during a busy run, to show that a restart would inflate the read count.

// File: rtl/tpc_pkg.sv
// Shared types for the toggle-bit completion poller.
// Assumes: nothing beyond a 1800-2017 compliant tool.
package tpc_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_FIRST  = 2'd1,
        ST_RD_SECOND = 2'd2,
        ST_RST_WR    = 2'd3
    } tpc_state_e;

    // Verdict produced at the end of each read pair.
    typedef enum logic [1:0] {
        ACT_DONE    = 2'd0,
        ACT_REPOLL  = 2'd1,
        ACT_RECHECK = 2'd2,
        ACT_FAIL    = 2'd3
    } tpc_action_e;

endpackage

// File: rtl/tpc_pair_judge.sv
// Keeps the toggle bit from the first read of a pair and, when the second
// read arrives, decides what the controller does next.
// Assumes: first_load and the second read never occur in the same cycle;
// the verdict is only meaningful in the cycle the second read is acknowledged.
module tpc_pair_judge
    import tpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        first_load,
    input  logic        toggle_in,
    input  logic        timeout_in,
    input  logic        recheck_armed,
    input  logic        final_pair,
    output tpc_action_e action
);

    logic first_toggle_q;
    logic toggle_moved;

    // Capture the toggle bit of the first read of each pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_toggle_q <= 1'b0;
        end else if (first_load) begin
            first_toggle_q <= toggle_in;
        end
    end

    assign toggle_moved = first_toggle_q ^ toggle_in;

    // Rank the outcomes: a match always wins, then recheck failure, budget, timeout.
    always_comb begin
        if (!toggle_moved) begin
            action = ACT_DONE;
        end else if (recheck_armed || final_pair) begin
            action = ACT_FAIL;
        end else if (timeout_in) begin
            action = ACT_RECHECK;
        end else begin
            action = ACT_REPOLL;
        end
    end

endmodule

// File: rtl/tpc_pair_budget.sv
// Counts completed read pairs of one operation and flags the last allowed one.
// Assumes: MAX_PAIRS >= 1; clear and pair_end are never high together.
module tpc_pair_budget #(
    parameter int MAX_PAIRS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pair_end,
    output logic final_pair
);

    localparam int CNT_W = $clog2(MAX_PAIRS + 1);

    logic [CNT_W-1:0] pairs_q;

    // Count finished pairs, restarting at each accepted start, saturating at the cap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pairs_q <= '0;
        end else if (clear) begin
            pairs_q <= '0;
        end else if (pair_end && (pairs_q != CNT_W'(MAX_PAIRS))) begin
            pairs_q <= pairs_q + CNT_W'(1);
        end
    end

    // The pair now ending is the last the budget permits.
    assign final_pair = (pairs_q == CNT_W'(MAX_PAIRS - 1));

    // R8: the count never passes the cap.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pairs_q <= CNT_W'(MAX_PAIRS));

    // R8: a start restarts the budget.
    a_r8_budget_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pairs_q == '0));

endmodule

// File: rtl/toggle_poll_ctrl.sv
// Host-side poller that reads a flash status word in pairs, compares one
// toggle bit, honours a timeout bit with a mandatory recheck pair, caps the
// number of pairs, and writes a reset command on failure.
// Assumes: rd_data is valid in every cycle rd_ack is high; the device side
// keeps acknowledges low while the matching request is low.
module toggle_poll_ctrl
    import tpc_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 16,
    parameter int                TOGGLE_BIT  = 6,
    parameter int                TIMEOUT_BIT = 5,
    parameter int                MAX_PAIRS   = 1024,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] RESET_ADDR  = ADDR_W'(16'h0555),
    parameter logic [DATA_W-1:0] RESET_CMD   = DATA_W'(8'hF0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done,
    output logic              fail
);

    tpc_state_e  state_q, state_d;
    tpc_action_e verdict;
    logic        recheck_q;
    logic        done_q;
    logic        fail_q;
    logic        accept_start;
    logic        first_ack;
    logic        second_ack;
    logic        final_pair;
    logic        unused_data;

    assign accept_start = start && (state_q == ST_IDLE);
    assign first_ack    = (state_q == ST_RD_FIRST)  && rd_ack;
    assign second_ack   = (state_q == ST_RD_SECOND) && rd_ack;
    assign unused_data  = ^rd_data;

    tpc_pair_judge u_judge (
        .clk           (clk),
        .rst_n         (rst_n),
        .first_load    (first_ack),
        .toggle_in     (rd_data[TOGGLE_BIT]),
        .timeout_in    (rd_data[TIMEOUT_BIT]),
        .recheck_armed (recheck_q),
        .final_pair    (final_pair),
        .action        (verdict)
    );

    tpc_pair_budget #(
        .MAX_PAIRS (MAX_PAIRS)
    ) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept_start),
        .pair_end   (second_ack),
        .final_pair (final_pair)
    );

    // Next-state selection for the read/verdict/reset-write sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)  state_d = ST_RD_FIRST;
            ST_RD_FIRST:  if (rd_ack) state_d = ST_RD_SECOND;
            ST_RD_SECOND: if (rd_ack) begin
                              unique case (verdict)
                                  ACT_DONE: state_d = ST_IDLE;
                                  ACT_FAIL: state_d = ST_RST_WR;
                                  default:  state_d = ST_RD_FIRST;
                              endcase
                          end
            ST_RST_WR:    if (wr_ack) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Arm the single recheck pair once the timeout bit is seen with a moving toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || accept_start)                  recheck_q <= 1'b0;
        else if (second_ack && verdict == ACT_RECHECK) recheck_q <= 1'b1;
    end

    // Registered success pulse and sticky failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= second_ack && (verdict == ACT_DONE);
            if (accept_start)                           fail_q <= 1'b0;
            else if (second_ack && verdict == ACT_FAIL) fail_q <= 1'b1;
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign rd_req  = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND);
    assign rd_addr = rd_req ? STATUS_ADDR : '0;
    assign wr_req  = (state_q == ST_RST_WR);
    assign wr_addr = wr_req ? RESET_ADDR : '0;
    assign wr_data = wr_req ? RESET_CMD : '0;
    assign done    = done_q;
    assign fail    = fail_q;

    // R2: a read request is held until acknowledged.
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);

    // R9: busy only rises in answer to a start pulse.
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3: done is a single-cycle pulse.
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done is given with the poller idle and not failed.
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !fail && !wr_req));

    // R7: the reset write is held until acknowledged and never overlaps a read.
    a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    // R7: the reset write only happens with the fail flag set.
    a_r7_wr_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> fail);

    // R10: fail only drops after an accepted start.
    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !(start && !busy) |=> fail);

endmodule

// File: tb/toggle_poll_ctrl_bench.sv
`timescale 1ns/1ps
module toggle_poll_ctrl_bench;

    localparam int          DW        = 8;
    localparam int          AW        = 16;
    localparam int          PAIRS     = 6;
    localparam logic [15:0] ST_ADDR   = 16'h0AAA;
    localparam logic [15:0] RS_ADDR   = 16'h0555;
    localparam logic [7:0]  RS_CMD    = 8'hF0;

    // Vector: toggling reads N, timeout-from-read D, ack wait, expect fail, expected reads.
    localparam int NV = 10;
    localparam logic [28:0] VECS [0:NV-1] = '{
        {8'd0,  8'd99, 4'd0, 1'b0, 8'd2},   // R3 stopped at once
        {8'd1,  8'd99, 4'd1, 1'b0, 8'd4},   // R4 one repoll
        {8'd5,  8'd99, 4'd0, 1'b0, 8'd8},   // R4 several repolls
        {8'd20, 8'd3,  4'd2, 1'b1, 8'd6},   // R6 recheck still moving
        {8'd4,  8'd3,  4'd0, 1'b0, 8'd6},   // R5 stops as timeout rises
        {8'd20, 8'd99, 4'd0, 1'b1, 8'd12},  // R8 budget exhausted
        {8'd11, 8'd99, 4'd1, 1'b1, 8'd12},  // R8 one pair too many
        {8'd10, 8'd99, 4'd0, 1'b0, 8'd12},  // R8 success on last pair
        {8'd3,  8'd0,  4'd0, 1'b1, 8'd4},   // R6 timeout on first pair
        {8'd2,  8'd0,  4'd3, 1'b0, 8'd4}    // R5 recheck matches
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          rd_req, rd_ack = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          wr_req, wr_ack = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          busy, done, fail;

    int checks = 0;
    int errors = 0;
    int m_n = 0, m_d = 99, m_wait = 0;
    int rd_cnt = 0, wr_cnt = 0, bad_addr = 0, waited = 0;
    logic [AW-1:0] seen_waddr = '0;
    logic [DW-1:0] seen_wdata = '0;

    always #5 clk = ~clk;

    toggle_poll_ctrl #(
        .DATA_W (DW), .ADDR_W (AW), .TOGGLE_BIT (6), .TIMEOUT_BIT (5),
        .MAX_PAIRS (PAIRS), .STATUS_ADDR (ST_ADDR), .RESET_ADDR (RS_ADDR),
        .RESET_CMD (RS_CMD)
    ) u_toggle_poll_ctrl (
        .clk (clk), .rst_n (rst_n), .start (start),
        .rd_req (rd_req), .rd_addr (rd_addr), .rd_ack (rd_ack), .rd_data (rd_data),
        .wr_req (wr_req), .wr_addr (wr_addr), .wr_data (wr_data), .wr_ack (wr_ack),
        .busy (busy), .done (done), .fail (fail)
    );

    function automatic logic [7:0] status_word(int k);
        logic [7:0] w;
        int lim;
        lim  = (k < m_n) ? k : m_n;
        w    = 8'h01;
        w[6] = lim[0];
        w[5] = (k >= m_d);
        w[2] = k[0];           // noise bit that toggles on every read
        return w;
    endfunction

    // Behavioural device: answers requests at the falling edge after a wait.
    initial begin
        forever begin
            @(negedge clk);
            rd_ack = 1'b0;
            wr_ack = 1'b0;
            if (rd_req) begin
                if (waited < m_wait) begin
                    waited++;
                end else begin
                    waited = 0;
                    if (rd_addr != ST_ADDR) bad_addr++;
                    rd_data = status_word(rd_cnt);
                    rd_ack  = 1'b1;
                    rd_cnt++;
                end
            end else if (wr_req) begin
                if (waited < m_wait) begin
                    waited++;
                end else begin
                    waited = 0;
                    seen_waddr = wr_addr;
                    seen_wdata = wr_data;
                    wr_ack = 1'b1;
                    wr_cnt++;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input int n, input int d, input int w, input bit ef,
                          input int er, input bit glitch, input string tag);
        int dones = 0;
        int iter  = 0;
        m_n = n; m_d = d; m_wait = w;
        rd_cnt = 0; wr_cnt = 0; bad_addr = 0; waited = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
        check(fail == 1'b0, {tag, " R10 fail cleared by start"}, fail, 0);
        while (busy && iter < 2000) begin
            @(negedge clk);
            iter++;
            start = glitch && (iter == 3);
            if (done) dones++;
        end
        start = 1'b0;
        check(fail == ef, {tag, " R6 R8 outcome"}, fail, ef);
        check(dones == (ef ? 0 : 1), {tag, " R3 done pulses"}, dones, ef ? 0 : 1);
        check(rd_cnt == er, {tag, " R4 R5 read count"}, rd_cnt, er);
        check(wr_cnt == (ef ? 1 : 0), {tag, " R7 reset writes"}, wr_cnt, ef ? 1 : 0);
        check(bad_addr == 0, {tag, " R2 status address"}, bad_addr, 0);
        if (ef) begin
            check(seen_waddr == RS_ADDR, {tag, " R7 write address"}, seen_waddr, RS_ADDR);
            check(seen_wdata == RS_CMD, {tag, " R7 write data"}, seen_wdata, RS_CMD);
        end
        @(negedge clk);
        check(done == 1'b0, {tag, " R3 done one cycle"}, done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, fail, rd_req, wr_req} == 5'b0, "R1 outputs in reset",
              {busy, done, fail, rd_req, wr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, fail, rd_req, wr_req} == 5'b0, "R1 outputs after reset",
              {busy, done, fail, rd_req, wr_req}, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(int'(VECS[i][28:21]), int'(VECS[i][20:13]), int'(VECS[i][12:9]),
                   VECS[i][8], int'(VECS[i][7:0]), 1'b0, $sformatf("vec%0d", i));
        end

        // R10: a failure stays flagged while idle, then a start clears it.
        run_op(20, 99, 0, 1'b1, 12, 1'b0, "r10_setup");
        repeat (5) @(negedge clk);
        check(fail == 1'b1, "R10 fail held while idle", fail, 1);
        run_op(0, 99, 0, 1'b0, 2, 1'b0, "r10_clear");

        // R9: a start pulse in the middle of a run changes nothing.
        run_op(5, 99, 3, 1'b0, 8, 1'b1, "r9_glitch");
        run_op(3, 0, 2, 1'b1, 4, 1'b1, "r9_glitch_fail");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule